// File: doc/BRIEF.md
# Periodic Memory Integrity Monitor

This block watches two pieces of on-chip storage and drives two level fault flags into the fault register. The first check covers a volatile register. At reset that register is loaded with a fixed constant held in a ROM model. On every microsecond tick it is compared against that ROM constant. If the two differ, the volatile-check flag `por_fault` goes high. The register is reloaded only by reset, which models a power cycle. A test-only injection input can flip bits of the volatile copy so the check can be exercised.

The second check runs on a slower schedule. It scans an external configuration memory through a synchronous read port, one word per clock. It adds up every word except two excluded addresses in a wrapping accumulator. At the end of each scan it compares the total with a reference checksum and drives `nvm_fault`. Both flags are levels: each one is re-evaluated at its own check instant and held in between. Making a flag sticky is the job of the fault register downstream.

Both intervals come from one prescaler. It divides the system clock by `US_DIV` to make the microsecond tick, and counts `SCAN_US` ticks between scans.

Top module: `mem_integrity_mon`

## Requirements
- R1: While reset is applied and in the first cycle after it, `por_fault`, `nvm_fault` and `mem_rd` are low. The volatile register holds the ROM constant `ROM_VALUE`, so with no injection `por_fault` never rises.
- R2: `por_fault` changes only at the clock edge that ends a tick cycle. Tick cycles occur every `US_DIV` cycles, and the first update falls on edge number `US_DIV` after reset release.
- R3: At each update, `por_fault` becomes 1 if the volatile register differs from the ROM constant in any bit, and 0 otherwise. It therefore stays high for as long as the mismatch persists.
- R4: The volatile register is never reloaded from ROM during operation. Applying reset restores it, and `por_fault` is then low and stays low.
- R5: A cycle with `inj_en` high XORs `inj_mask` into the volatile register at that edge. A zero mask has no effect, and applying the same mask twice restores the original value.
- R6: A scan starts at edge `US_DIV*SCAN_US` after reset and then every `US_DIV*SCAN_US` cycles. It holds `mem_rd` high for `WORDS` consecutive cycles with `mem_addr` counting 0, 1, ... `WORDS-1`. `mem_rd` is low at all other times. Read data is expected on `mem_data` one cycle after the address.
- R7: `nvm_fault` is updated once per scan, at the edge one cycle after the data of the last address arrives (edge start+`WORDS`+1). It becomes 1 when the `DATA_W`-bit wrap-around sum of the included words differs from `ref_sum` sampled at that edge, and it holds that value until the next scan's verdict.
- R8: The words at addresses `SKIP_A` and `SKIP_B` are excluded from the sum. Their contents have no effect on `nvm_fault`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-cycle model) |
| inj_en | input | 1 | Apply `inj_mask` to the volatile copy this cycle |
| inj_mask | input | DATA_W | Bits to flip in the volatile copy |
| mem_rd | output | 1 | Read strobe to configuration memory |
| mem_addr | output | $clog2(WORDS) | Read address |
| mem_data | input | DATA_W | Read data, valid one cycle after the strobe |
| ref_sum | input | DATA_W | Stored reference checksum |
| por_fault | output | 1 | Volatile-copy mismatch flag (level) |
| nvm_fault | output | 1 | Checksum mismatch flag (level) |

## Verification
The bench pins down the exact edges at which each flag may move.
- **Tick timing.** A corruption injected a few cycles before a tick must not be visible until that tick, so a compare that runs every cycle is caught.
- **Verdict timing.** The checksum verdict is sampled one cycle either side of its edge. An accumulator that drops the last word, or registers the verdict a cycle late, gives the wrong value there.
- **Excluded words.** The two excluded words are filled with garbage while the reference is left alone. A walker that ignores the skip list, or skips the wrong address, raises `nvm_fault`.
- **Wrapping sum.** Words whose total overflows are used with a reference computed modulo 2^16, so a carry that is folded back or saturated shows up.
- **Reload rule.** A corruption must persist across ticks until a reset, which catches a design that reloads the shadow register at every compare.

// File: rtl/imon_pkg.sv
package imon_pkg;

   typedef enum logic [0:0] {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;

   // Tag carried alongside a read so the returning data knows its role.
   typedef struct packed {
      logic valid;
      logic skip;
      logic last;
   } rd_tag_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/imon_prescaler.sv
module imon_prescaler #(
   parameter int unsigned US_DIV  = 200,
   parameter int unsigned SCAN_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   output logic us_tick,
   output logic scan_go
);
   localparam int unsigned UCW = imon_pkg::cnt_width(US_DIV);
   localparam int unsigned SCW = imon_pkg::cnt_width(SCAN_US);

   generate
      if (US_DIV == 1) begin : g_tick_every
         assign us_tick = 1'b1;
      end else begin : g_tick_div
         localparam logic [UCW-1:0] U_LAST = UCW'(US_DIV - 1);
         logic [UCW-1:0] ucnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ucnt <= '0;
            else if (ucnt == U_LAST)
               ucnt <= '0;
            else
               ucnt <= ucnt + 1'b1;
         end
         assign us_tick = (ucnt == U_LAST);
      end

      if (SCAN_US == 1) begin : g_scan_every
         assign scan_go = us_tick;
      end else begin : g_scan_div
         localparam logic [SCW-1:0] S_LAST = SCW'(SCAN_US - 1);
         logic [SCW-1:0] scnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               scnt <= '0;
            else if (us_tick) begin
               if (scnt == S_LAST)
                  scnt <= '0;
               else
                  scnt <= scnt + 1'b1;
            end
         end
         assign scan_go = us_tick && (scnt == S_LAST);
      end
   endgenerate

endmodule

// File: rtl/imon_rom.sv
module imon_rom #(
   parameter int unsigned          DATA_W = 16,
   parameter logic [DATA_W-1:0]    VALUE  = '0
) (
   output logic [DATA_W-1:0] rom_word
);
   assign rom_word = VALUE;
endmodule

// File: rtl/imon_shadow.sv
module imon_shadow #(
   parameter int unsigned          DATA_W    = 16,
   parameter logic [DATA_W-1:0]    ROM_VALUE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic              inj_en,
   input  logic [DATA_W-1:0] inj_mask,
   output logic              por_fault
);
   logic [DATA_W-1:0] rom_word;
   logic [DATA_W-1:0] shadow_q;

   imon_rom #(.DATA_W(DATA_W), .VALUE(ROM_VALUE)) u_rom (.rom_word(rom_word));

   // Volatile copy: seeded only by reset, otherwise touched only by injection.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow_q <= ROM_VALUE;
      else if (inj_en)
         shadow_q <= shadow_q ^ inj_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         por_fault <= 1'b0;
      else if (us_tick)
         por_fault <= (shadow_q != rom_word);
   end

endmodule

// File: rtl/imon_walker.sv
module imon_walker
   import imon_pkg::*;
#(
   parameter int unsigned WORDS  = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SKIP_A = 3,
   parameter int unsigned SKIP_B = 7,
   localparam int unsigned ADDR_W = cnt_width(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_go,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data,
   input  logic [DATA_W-1:0] ref_sum,
   output logic              pass_done,
   output logic              nvm_fault
);
   localparam logic [ADDR_W-1:0]   A_LAST    = ADDR_W'(WORDS - 1);
   localparam int unsigned         NSKIP     = 2;
   localparam int unsigned         SKIP_LIST [NSKIP] = '{SKIP_A, SKIP_B};

   walk_state_e       state;
   logic [ADDR_W-1:0] addr;
   rd_tag_t           tag;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] acc_next;
   logic [NSKIP-1:0]  skip_hit;

   generate
      for (genvar g = 0; g < NSKIP; g++) begin : g_skip
         assign skip_hit[g] = (32'(addr) == SKIP_LIST[g]);
      end
   endgenerate

   assign mem_rd    = (state == WALK_RUN);
   assign mem_addr  = addr;
   assign pass_done = tag.valid && tag.last;
   assign acc_next  = tag.skip ? acc : acc + mem_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= WALK_IDLE;
         addr  <= '0;
      end else begin
         unique case (state)
            WALK_IDLE: if (scan_go) begin
               state <= WALK_RUN;
               addr  <= '0;
            end
            WALK_RUN: begin
               if (addr == A_LAST)
                  state <= WALK_IDLE;
               else
                  addr <= addr + 1'b1;
            end
            default: state <= WALK_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tag <= '0;
      else begin
         tag.valid <= (state == WALK_RUN);
         tag.skip  <= |skip_hit;
         tag.last  <= (addr == A_LAST);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (state == WALK_IDLE && scan_go)
         acc <= '0;
      else if (tag.valid)
         acc <= acc_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         nvm_fault <= 1'b0;
      else if (pass_done)
         nvm_fault <= (acc_next != ref_sum);
   end

endmodule

// File: rtl/mem_integrity_mon.sv
module mem_integrity_mon #(
   parameter int unsigned          US_DIV    = 200,
   parameter int unsigned          SCAN_US   = 50,
   parameter int unsigned          WORDS     = 16,
   parameter int unsigned          DATA_W    = 16,
   parameter int unsigned          SKIP_A    = 3,
   parameter int unsigned          SKIP_B    = 7,
   parameter logic [DATA_W-1:0]    ROM_VALUE = 16'hA5C3,
   localparam int unsigned         ADDR_W    = imon_pkg::cnt_width(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inj_en,
   input  logic [DATA_W-1:0] inj_mask,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data,
   input  logic [DATA_W-1:0] ref_sum,
   output logic              por_fault,
   output logic              nvm_fault
);
   generate
      if (WORDS < 2)                     begin : g_bad_words  $error("WORDS must be at least 2");              end
      if (SKIP_A >= WORDS)               begin : g_bad_skipa  $error("SKIP_A outside memory");                 end
      if (SKIP_B >= WORDS)               begin : g_bad_skipb  $error("SKIP_B outside memory");                 end
      if (SKIP_A == SKIP_B)              begin : g_bad_skip   $error("excluded addresses must differ");        end
      if (DATA_W < 2)                    begin : g_bad_width  $error("DATA_W too small");                      end
      if (US_DIV * SCAN_US <= WORDS + 2) begin : g_bad_period $error("scan period shorter than one pass");     end
   endgenerate

   logic us_tick;
   logic scan_go;
   logic pass_done;

   imon_prescaler #(.US_DIV(US_DIV), .SCAN_US(SCAN_US)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .us_tick (us_tick),
      .scan_go (scan_go)
   );

   imon_shadow #(.DATA_W(DATA_W), .ROM_VALUE(ROM_VALUE)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .us_tick   (us_tick),
      .inj_en    (inj_en),
      .inj_mask  (inj_mask),
      .por_fault (por_fault)
   );

   imon_walker #(
      .WORDS  (WORDS),
      .DATA_W (DATA_W),
      .SKIP_A (SKIP_A),
      .SKIP_B (SKIP_B)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .scan_go   (scan_go),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .ref_sum   (ref_sum),
      .pass_done (pass_done),
      .nvm_fault (nvm_fault)
   );

endmodule

// File: rtl/imon_checker.sv
module imon_checker #(
   parameter int unsigned WORDS  = 16,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              us_tick,
   input logic              pass_done,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              por_fault,
   input logic              nvm_fault
);
   localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(WORDS - 1);

   AST_CLEAN_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !por_fault && !nvm_fault && !mem_rd);  // R1

   AST_POR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !us_tick |=> $stable(por_fault));  // R2

   AST_NVM_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_done |=> $stable(nvm_fault));  // R7

   AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> mem_addr <= A_LAST);  // R6

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && mem_addr != '0 |-> $past(mem_rd) && mem_addr == ADDR_W'($past(mem_addr) + 1'b1));  // R6

   AST_VERDICT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |-> $past(mem_rd) && !mem_rd);  // R7

endmodule

bind mem_integrity_mon imon_checker #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .us_tick   (us_tick),
   .pass_done (pass_done),
   .mem_rd    (mem_rd),
   .mem_addr  (mem_addr),
   .por_fault (por_fault),
   .nvm_fault (nvm_fault)
);

// File: tb/mem_integrity_mon_test.sv
`timescale 1ns/1ps
module mem_integrity_mon_test;
   localparam int unsigned US_DIV  = 10;
   localparam int unsigned SCAN_US = 5;
   localparam int unsigned WORDS   = 16;
   localparam int unsigned DW      = 16;
   localparam int unsigned SKA     = 3;
   localparam int unsigned SKB     = 12;
   localparam logic [15:0] ROMV    = 16'hA5C3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inj_en = 1'b0;
   logic [15:0] inj_mask = '0;
   logic        mem_rd;
   logic [3:0]  mem_addr;
   logic [15:0] mem_data = '0;
   logic [15:0] ref_sum = '0;
   logic        por_fault;
   logic        nvm_fault;

   logic [15:0] mem [WORDS];
   int unsigned cyc;
   int          total = 0;
   int          bad = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   mem_integrity_mon #(
      .US_DIV(US_DIV), .SCAN_US(SCAN_US), .WORDS(WORDS), .DATA_W(DW),
      .SKIP_A(SKA), .SKIP_B(SKB), .ROM_VALUE(ROMV)
   ) uut (
      .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .inj_mask(inj_mask),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
      .ref_sum(ref_sum), .por_fault(por_fault), .nvm_fault(nvm_fault)
   );

   // synchronous memory model, one cycle read latency
   always @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr];

   always @(posedge clk or negedge rst_n)
      if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h (cyc %0d)", req, act, exp, cyc);
      end
   endtask

   // return at the falling edge that follows rising edge number n
   task automatic wait_cyc(input int unsigned n);
      do @(negedge clk); while (cyc < n);
   endtask

   function automatic logic [15:0] exp_sum();
      logic [15:0] s = '0;
      for (int i = 0; i < WORDS; i++)
         if (i != SKA && i != SKB) s = s + mem[i];
      return s;
   endfunction

   // volatile copy is XORed at edge number n
   task automatic inject(input int unsigned n, input logic [15:0] m);
      wait_cyc(n - 1);
      inj_en = 1'b1; inj_mask = m;
      @(negedge clk);
      inj_en = 1'b0; inj_mask = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!por_fault && !nvm_fault && !mem_rd, "R1 during reset", {por_fault, nvm_fault, mem_rd}, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      wait_cyc(5);
      chk(!por_fault, "R1 por after reset", por_fault, 0);
      chk(!nvm_fault, "R1 nvm after reset", nvm_fault, 0);
      chk(!mem_rd, "R1 no read before first scan", mem_rd, 0);
   endtask

   // first scan starts at edge 50, verdict at edge 67; reference deliberately wrong
   task automatic t_first_scan();
      ref_sum = exp_sum() + 16'd1;
      wait_cyc(49);
      chk(!mem_rd, "R6 idle before scan", mem_rd, 0);
      wait_cyc(50);
      chk(mem_rd && mem_addr == 0, "R6 scan start addr 0", {mem_rd, mem_addr}, {1'b1, 4'd0});
      wait_cyc(51);
      chk(mem_rd && mem_addr == 1, "R6 scan step addr 1", {mem_rd, mem_addr}, {1'b1, 4'd1});
      wait_cyc(65);
      chk(mem_rd && mem_addr == 15, "R6 last addr", {mem_rd, mem_addr}, {1'b1, 4'd15});
      wait_cyc(66);
      chk(!mem_rd, "R6 read stops after last word", mem_rd, 0);
      chk(!nvm_fault, "R7 verdict not before its edge", nvm_fault, 0);
      wait_cyc(67);
      chk(nvm_fault, "R7 bad checksum flagged", nvm_fault, 1);
   endtask

   task automatic t_ref_fix();
      wait_cyc(70);
      ref_sum = exp_sum();
      wait_cyc(116);
      chk(nvm_fault, "R7 level held until next verdict", nvm_fault, 1);
      wait_cyc(117);
      chk(!nvm_fault, "R7 good checksum clears flag", nvm_fault, 0);
   endtask

   task automatic t_skip();
      wait_cyc(120);
      mem[SKA] = 16'hDEAD;
      mem[SKB] = 16'hBEEF;
      wait_cyc(170);
      chk(!nvm_fault, "R8 excluded words ignored", nvm_fault, 0);
      wait_cyc(172);
      mem[5] = mem[5] ^ 16'h0001;
      wait_cyc(217);
      chk(nvm_fault, "R7 included word change flagged", nvm_fault, 1);
      wait_cyc(220);
      mem[5] = mem[5] ^ 16'h0001;
      wait_cyc(267);
      chk(!nvm_fault, "R7 restored word clears flag", nvm_fault, 0);
   endtask

   task automatic t_zero_mask();
      inject(272, 16'h0000);
      wait_cyc(281);
      chk(!por_fault, "R5 zero mask no effect", por_fault, 0);
   endtask

   task automatic t_wrap();
      wait_cyc(285);
      for (int i = 0; i < WORDS; i++) mem[i] = 16'hF000 + 16'(i);
      ref_sum = exp_sum();
      wait_cyc(317);
      chk(!nvm_fault, "R7 wrap-around sum accepted", nvm_fault, 0);
   endtask

   task automatic t_por();
      inject(322, 16'h0100);
      wait_cyc(329);
      chk(!por_fault, "R2 no update before tick", por_fault, 0);
      wait_cyc(330);
      chk(por_fault, "R3 mismatch flagged at tick", por_fault, 1);
      wait_cyc(345);
      chk(por_fault, "R4 corruption not reloaded", por_fault, 1);
      inject(352, 16'h0100);
      wait_cyc(359);
      chk(por_fault, "R2 held until tick", por_fault, 1);
      wait_cyc(360);
      chk(!por_fault, "R5 double mask restores", por_fault, 0);
      inject(362, 16'h8001);
      wait_cyc(370);
      chk(por_fault, "R3 multi-bit mismatch", por_fault, 1);
   endtask

   task automatic t_reload();
      do_reset();
      wait_cyc(5);
      chk(!por_fault, "R4 reset clears flag", por_fault, 0);
      wait_cyc(11);
      chk(!por_fault, "R4 reset reloads copy", por_fault, 0);
      wait_cyc(25);
      chk(!por_fault, "R4 copy stays good", por_fault, 0);
   endtask

   initial begin
      for (int i = 0; i < WORDS; i++) mem[i] = 16'h1000 + 16'(i * 16'h0111);
      do_reset();
      t_reset_state();
      t_first_scan();
      t_ref_fix();
      t_skip();
      t_zero_mask();
      t_wrap();
      t_por();
      t_reload();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule